// File: doc/BRIEF.md
# Line-Dependent Load-Line Reference Generator

This block produces the output-voltage setpoint for a digital boost power-factor-correction controller. Each accepted sample carries the RMS input voltage and the output power. The RMS voltage places the converter in one of three load-line regimes: top, high-line or low-line. In the top regime the setpoint is one flat programmed voltage. In the other two regimes the setpoint follows a straight line between two programmed voltages as power moves across a programmed power window. Outside that window the setpoint is clamped to the nearer end.

Software sets the thresholds, voltages and power limits through a simple write port. Each accepted sample produces exactly one registered setpoint, marked by a one-cycle strobe. A sample that lands on a clamp returns one cycle after it is accepted. A sample inside the window goes through a sequential divider and takes longer; new samples are refused while the divider is working.

Top module: `llr_ref_gen`

## Requirements
- R1: During reset and in the first cycle after it, `ref_out` is 0, `out_valid` is 0 and `in_ready` is 1. The regime after reset is low-line.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the register at `cfg_addr`. The addresses are: 0 top voltage, 1 high-line start voltage, 2 high-line end voltage, 3 low-line start voltage, 4 low-line end voltage, 5 window start power P1, 6 window end power P2, 7 top threshold, 8 top hysteresis, 9 high-line threshold, 10 low-line threshold. A write to addresses 11 to 15 changes nothing.
- R3: A sample with `vin_rms` strictly above the top threshold selects the top regime. There the result equals the top voltage for any power.
- R4: Once in the top regime, the block stays there while `vin_rms` is at or above the top threshold minus the hysteresis (floored at 0). It leaves the top regime when `vin_rms` falls below that level.
- R5: When the top regime does not apply and `vin_rms` is at or above the high-line threshold, the high-line start and end voltages are used.
- R6: When the top regime does not apply and `vin_rms` is below the low-line threshold, the low-line start and end voltages are used.
- R7: A sample between the low-line and high-line thresholds keeps the previous regime. The exception is the top regime: on exit from it into this band, the high-line regime is chosen.
- R8: Power at or below P1 gives the start voltage V1. Power at or above P2 gives the end voltage V2.
- R9: For P1 < power < P2 the result is V1 ± floor(|V2−V1|·(power−P1)/(P2−P1)). The sign is + when V2 ≥ V1 and − otherwise.
- R10: When P2 ≤ P1, power at or below P1 gives V1 and any higher power gives V2.
- R11: `out_valid` pulses for exactly one cycle per accepted sample. `ref_out` holds its value between pulses. While a division is in progress `in_ready` is 0, and samples offered then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | DW (12) | Register write data |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample |
| vin_rms | input | VW (12) | Measured RMS input voltage |
| pout | input | PW (12) | Measured output power |
| ref_out | output | VW (12) | Voltage setpoint |
| out_valid | output | 1 | One-cycle strobe for a new setpoint |

## Verification
The embedded properties check the following on every cycle:
- each strobed result lies between the two voltages chosen for it;
- a top-regime result equals the top voltage;
- the setpoint holds still between strobes;
- the ready signal stays low while the divider is busy;
- regime entry for samples above the top threshold and below the low-line threshold;
- the dead band keeps the regime;
- the divider's done flag is a single pulse.

Only the directed scenarios can show the following:
- the exact interpolated values and their floor rounding in both directions;
- the hysteresis boundaries;
- the step behaviour when the window is inverted;
- that unmapped writes and samples offered while busy leave the output untouched.

// File: rtl/llr_pkg.sv
// Package: shared regime encoding and register address map for the
// load-line reference generator. Assumes a 4-bit register address.
package llr_pkg;

    typedef enum logic [1:0] {
        RG_LOW  = 2'd0,
        RG_HIGH = 2'd1,
        RG_TOP  = 2'd2
    } regime_e;

    localparam int AW = 4;

    localparam logic [AW-1:0] A_VTOP = 4'd0;
    localparam logic [AW-1:0] A_VH1  = 4'd1;
    localparam logic [AW-1:0] A_VH2  = 4'd2;
    localparam logic [AW-1:0] A_VL1  = 4'd3;
    localparam logic [AW-1:0] A_VL2  = 4'd4;
    localparam logic [AW-1:0] A_P1   = 4'd5;
    localparam logic [AW-1:0] A_P2   = 4'd6;
    localparam logic [AW-1:0] A_TSUP = 4'd7;
    localparam logic [AW-1:0] A_THYS = 4'd8;
    localparam logic [AW-1:0] A_THI  = 4'd9;
    localparam logic [AW-1:0] A_TLO  = 4'd10;

endpackage

// File: rtl/llr_cfg_regs.sv
// Setpoint register file: holds thresholds, voltages and power limits.
// Assumes DW >= VW and DW >= PW. Unmapped addresses are dropped.
module llr_cfg_regs #(
    parameter int VW = 12,
    parameter int PW = 12,
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [llr_pkg::AW-1:0] addr,
    input  logic [DW-1:0]        wdata,
    output logic [VW-1:0]        v_top,
    output logic [VW-1:0]        v_h1,
    output logic [VW-1:0]        v_h2,
    output logic [VW-1:0]        v_l1,
    output logic [VW-1:0]        v_l2,
    output logic [PW-1:0]        p1,
    output logic [PW-1:0]        p2,
    output logic [VW-1:0]        t_sup,
    output logic [VW-1:0]        t_hys,
    output logic [VW-1:0]        t_hi,
    output logic [VW-1:0]        t_lo
);
    import llr_pkg::*;

    logic [VW-1:0] wv;
    logic [PW-1:0] wp;

    // Purpose: slice write data to the voltage and power widths.
    always_comb begin
        wv = wdata[VW-1:0];
        wp = wdata[PW-1:0];
    end

    // Purpose: store one register per mapped address write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_top <= '0; v_h1 <= '0; v_h2 <= '0; v_l1 <= '0; v_l2 <= '0;
            p1 <= '0; p2 <= '0;
            t_sup <= '0; t_hys <= '0; t_hi <= '0; t_lo <= '0;
        end else if (we) begin
            case (addr)
                A_VTOP:  v_top <= wv;
                A_VH1:   v_h1  <= wv;
                A_VH2:   v_h2  <= wv;
                A_VL1:   v_l1  <= wv;
                A_VL2:   v_l2  <= wv;
                A_P1:    p1    <= wp;
                A_P2:    p2    <= wp;
                A_TSUP:  t_sup <= wv;
                A_THYS:  t_hys <= wv;
                A_THI:   t_hi  <= wv;
                A_TLO:   t_lo  <= wv;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/llr_regime_sel.sv
// Regime selector: classifies each accepted sample into low-line,
// high-line or top regime, with hysteresis on the top threshold and a
// hold band between the low and high thresholds. Provides the next
// regime combinationally so the datapath can use it in the accept cycle.
module llr_regime_sel #(
    parameter int VW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [VW-1:0]    vin,
    input  logic [VW-1:0]    t_sup,
    input  logic [VW-1:0]    t_hys,
    input  logic [VW-1:0]    t_hi,
    input  logic [VW-1:0]    t_lo,
    output llr_pkg::regime_e rg_next,
    output llr_pkg::regime_e rg_q
);
    import llr_pkg::*;

    logic [VW-1:0] exit_lvl;

    // Purpose: level below which the top regime is released (floored at 0).
    always_comb begin
        exit_lvl = (t_hys > t_sup) ? '0 : (t_sup - t_hys);
    end

    // Purpose: choose the regime for the sample being offered.
    always_comb begin
        if (vin > t_sup)                         rg_next = RG_TOP;
        else if (rg_q == RG_TOP && vin >= exit_lvl) rg_next = RG_TOP;
        else if (vin >= t_hi)                    rg_next = RG_HIGH;
        else if (vin < t_lo)                     rg_next = RG_LOW;
        else if (rg_q == RG_TOP)                 rg_next = RG_HIGH;
        else                                     rg_next = rg_q;
    end

    // Purpose: update the held regime on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   rg_q <= RG_LOW;
        else if (acc) rg_q <= rg_next;
    end

    p_top_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && vin > t_sup) |=> (rg_q == RG_TOP));

    p_low_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && vin < t_lo && vin < t_hi && rg_q != RG_TOP) |=> (rg_q == RG_LOW));

    p_dead_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && vin >= t_lo && vin < t_hi && rg_q != RG_TOP) |=> $stable(rg_q));

endmodule

// File: rtl/llr_divider.sv
// Sequential restoring divider: one quotient bit per cycle, NW cycles per
// division. Assumes a nonzero divisor and a quotient that fits OW bits.
// Outputs the low OW quotient bits with a one-cycle done pulse.
module llr_divider #(
    parameter int NW = 24,
    parameter int DWD = 12,
    parameter int OW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   num,
    input  logic [DWD-1:0]  den,
    output logic            busy,
    output logic            done,
    output logic [OW-1:0]   quo_o
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0]  quo;
    logic [DWD-1:0] rem;
    logic [DWD-1:0] den_q;
    logic [CW-1:0]  cnt;
    logic [DWD:0]   rem_sh;
    logic           fit;

    // Purpose: shift in the next dividend bit and test against the divisor.
    always_comb begin
        rem_sh = {rem, quo[NW-1]};
        fit    = (rem_sh >= {1'b0, den_q});
    end

    // Purpose: run the shift-subtract iterations and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo <= '0; rem <= '0; den_q <= '0; cnt <= '0;
            busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                quo   <= num;
                rem   <= '0;
                den_q <= den;
                cnt   <= CW'(NW);
                busy  <= 1'b1;
            end else if (busy) begin
                rem  <= fit ? DWD'(rem_sh - {1'b0, den_q}) : rem_sh[DWD-1:0];
                quo  <= {quo[NW-2:0], fit};
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo[OW-1:0];

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/llr_ref_gen.sv
// Load-line reference generator top. Per accepted sample it picks the
// regime, selects the two endpoint voltages, and either returns a clamp
// value next cycle or interpolates through the sequential divider.
// Assumes P1 < power < P2 whenever the divider is started.
module llr_ref_gen #(
    parameter int VW = 12,
    parameter int PW = 12,
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [llr_pkg::AW-1:0] cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [VW-1:0]        vin_rms,
    input  logic [PW-1:0]        pout,
    output logic [VW-1:0]        ref_out,
    output logic                 out_valid
);
    import llr_pkg::*;

    localparam int NW = VW + PW;

    logic [VW-1:0] v_top, v_h1, v_h2, v_l1, v_l2, t_sup, t_hys, t_hi, t_lo;
    logic [PW-1:0] p1, p2;
    regime_e       rg_next, rg_q;

    logic          acc, clamp_lo, clamp_hi, div_start, div_busy, div_done;
    logic [VW-1:0] sel_v1, sel_v2, mag, q_w;
    logic [PW-1:0] pdel, pspan;
    logic [NW-1:0] num;
    logic [VW-1:0] cap_v1, cap_v2;
    logic          cap_dec, waiting;

    llr_cfg_regs #(.VW(VW), .PW(PW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .v_top(v_top), .v_h1(v_h1), .v_h2(v_h2), .v_l1(v_l1), .v_l2(v_l2),
        .p1(p1), .p2(p2), .t_sup(t_sup), .t_hys(t_hys), .t_hi(t_hi), .t_lo(t_lo)
    );

    llr_regime_sel #(.VW(VW)) u_rg (
        .clk(clk), .rst_n(rst_n), .acc(acc), .vin(vin_rms),
        .t_sup(t_sup), .t_hys(t_hys), .t_hi(t_hi), .t_lo(t_lo),
        .rg_next(rg_next), .rg_q(rg_q)
    );

    llr_divider #(.NW(NW), .DWD(PW), .OW(VW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(num), .den(pspan),
        .busy(div_busy), .done(div_done), .quo_o(q_w)
    );

    assign in_ready = !waiting;
    assign acc      = in_valid && in_ready;

    // Purpose: pick endpoint voltages and clamp decisions for the offered sample.
    always_comb begin
        case (rg_next)
            RG_TOP:  begin sel_v1 = v_top; sel_v2 = v_top; end
            RG_HIGH: begin sel_v1 = v_h1;  sel_v2 = v_h2;  end
            default: begin sel_v1 = v_l1;  sel_v2 = v_l2;  end
        endcase
        clamp_lo  = (rg_next == RG_TOP) || (pout <= p1);
        clamp_hi  = (pout >= p2);
        mag       = (sel_v2 >= sel_v1) ? (sel_v2 - sel_v1) : (sel_v1 - sel_v2);
        pdel      = pout - p1;
        pspan     = p2 - p1;
        num       = NW'(mag) * NW'(pdel);
        div_start = acc && !clamp_lo && !clamp_hi;
    end

    // Purpose: register the setpoint, the strobe and the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_out <= '0; out_valid <= 1'b0; waiting <= 1'b0;
            cap_v1 <= '0; cap_v2 <= '0; cap_dec <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (acc) begin
                cap_v1  <= sel_v1;
                cap_v2  <= sel_v2;
                cap_dec <= (sel_v2 < sel_v1);
                if (clamp_lo) begin
                    ref_out <= sel_v1; out_valid <= 1'b1;
                end else if (clamp_hi) begin
                    ref_out <= sel_v2; out_valid <= 1'b1;
                end else begin
                    waiting <= 1'b1;
                end
            end else if (waiting && div_done) begin
                ref_out   <= cap_dec ? (cap_v1 - q_w) : (cap_v1 + q_w);
                out_valid <= 1'b1;
                waiting   <= 1'b0;
            end
        end
    end

    p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((ref_out >= cap_v1 && ref_out <= cap_v2) ||
                       (ref_out <= cap_v1 && ref_out >= cap_v2)));

    p_top_flat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rg_q == RG_TOP) |-> (ref_out == $past(v_top)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(ref_out));

    p_busy_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !in_ready);

endmodule

// File: tb/tb_llr_ref_gen.sv
module tb_llr_ref_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] vin_rms = '0;
    logic [11:0] pout = '0;
    logic [11:0] ref_out;
    logic        out_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    llr_ref_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .vin_rms(vin_rms), .pout(pout), .ref_out(ref_out), .out_valid(out_valid)
    );

    // Programmed setpoints used by the expectations
    localparam int VTOP = 3000, VH1 = 2800, VH2 = 2600, VL1 = 2200, VL2 = 2500;
    localparam int P1 = 100, P2 = 1100;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lline(int v1, int v2, int p1, int p2, int p);
        int m;
        if (p <= p1) return v1;
        if (p >= p2) return v2;
        m = ((v2 >= v1) ? (v2 - v1) : (v1 - v2)) * (p - p1) / (p2 - p1);
        return (v2 >= v1) ? v1 + m : v1 - m;
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 12'(d);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic sample(string tag, int vin, int p, int exp);
        int res = -1;
        @(negedge clk); in_valid = 1'b1; vin_rms = 12'(vin); pout = 12'(p);
        @(negedge clk); in_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (out_valid) begin res = int'(ref_out); break; end
            @(negedge clk);
        end
        check(tag, res, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 ref_out", int'(ref_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ref_out after release", int'(ref_out), 0);
    endtask

    task automatic t_config();
        wr(0, VTOP); wr(1, VH1); wr(2, VH2); wr(3, VL1); wr(4, VL2);
        wr(5, P1); wr(6, P2); wr(7, 2500); wr(8, 160); wr(9, 1800); wr(10, 1400);
    endtask

    task automatic t_low();
        // R7: dead band right after reset uses low-line
        sample("R7 reset regime low", 1600, 600, lline(VL1, VL2, P1, P2, 600));
        sample("R6 R8 low clamp below", 1000, 50, VL1);
        sample("R6 R8 low clamp above", 1000, 2000, VL2);
        sample("R8 at P1", 1000, P1, VL1);
        sample("R8 at P2", 1000, P2, VL2);
        sample("R9 low rising floor", 1000, 433, lline(VL1, VL2, P1, P2, 433));
    endtask

    task automatic t_high();
        sample("R5 high mid", 2000, 600, lline(VH1, VH2, P1, P2, 600));
        sample("R9 high falling floor", 2000, 777, lline(VH1, VH2, P1, P2, 777));
        sample("R7 dead band keeps high", 1600, 600, lline(VH1, VH2, P1, P2, 600));
    endtask

    task automatic t_top();
        sample("R3 top low power", 2600, 50, VTOP);
        sample("R3 top high power", 2600, 4000, VTOP);
        sample("R3 top mid power", 2600, 600, VTOP);
    endtask

    task automatic t_hyst();
        sample("R4 stay top", 2400, 600, VTOP);
        sample("R4 stay top at exit level", 2340, 600, VTOP);
        sample("R4 leave top", 2339, 600, lline(VH1, VH2, P1, P2, 600));
        sample("R4 threshold not exceeded", 2500, 600, lline(VH1, VH2, P1, P2, 600));
        sample("R3 re-enter top", 2501, 600, VTOP);
        sample("R7 top exit into band", 1600, 600, lline(VH1, VH2, P1, P2, 600));
        sample("R6 back to low", 1000, 600, lline(VL1, VL2, P1, P2, 600));
    endtask

    task automatic t_step();
        wr(6, P1);
        sample("R10 equal at P1", 1000, P1, VL1);
        sample("R10 equal above P1", 1000, P1 + 1, VL2);
        wr(6, 50);
        sample("R10 inverted below", 1000, 80, VL1);
        sample("R10 inverted above", 1000, 150, VL2);
        wr(6, P2);
    endtask

    task automatic t_unmapped();
        wr(15, 0); wr(11, 7);
        sample("R2 unmapped write ignored", 1000, 600, lline(VL1, VL2, P1, P2, 600));
    endtask

    task automatic t_busy();
        int res = -1;
        int pulses = 0;
        @(negedge clk); in_valid = 1'b1; vin_rms = 12'd1000; pout = 12'd600;
        @(negedge clk); pout = 12'd50;
        check("R11 ready low while busy", int'(in_ready), 0);
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (out_valid) begin res = int'(ref_out); break; end
            @(negedge clk);
        end
        check("R11 busy sample ignored", res, lline(VL1, VL2, P1, P2, 600));
        @(negedge clk);
        check("R11 strobe one cycle", int'(out_valid), 0);
        for (int i = 0; i < 40; i++) begin
            if (out_valid) pulses++;
            @(negedge clk);
        end
        check("R11 no extra strobe", pulses, 0);
        check("R11 output holds", int'(ref_out), lline(VL1, VL2, P1, P2, 600));
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_config();
        t_low();
        t_high();
        t_top();
        t_hyst();
        t_step();
        t_unmapped();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule